// File: doc/BRIEF.md
# Wavefront Cross-Lane Permute Unit

This block reorders 32-bit words among the 64 lanes of a vector register. Each lane supplies a byte address and a data word. The address, plus a small zero-extended immediate, names a partner lane. Because a register slot is four bytes wide, the partner number is the word index of that sum, modulo 64. An execution mask chooses which lanes take part. A mode bit picks one of two directions. In gather mode a lane pulls in its partner's word. In scatter mode a lane pushes its own word into its partner's slot.

A partner lane that is masked off supplies zero instead of data. Result slots that no transfer writes keep the value of a prior-destination vector, so the caller sees a merge with the old register contents. A second immediate field is expected to be zero. If it is not zero, the block raises an error flag that travels with the operation, and the operation still runs using the first immediate only.

Operations enter through a valid/ready handshake and can be issued back to back, one per cycle. Every operand is registered at issue. A fixed-latency pipeline then returns the 64-lane result with a one-cycle done pulse for each accepted operation.

Top module: `lane_permute_unit`

## Requirements
- R1: The partner lane of lane i is bits [7:2] of (address_i + zero-extended offset0), so the partner is the word index modulo 64.
- R2: In gather mode (in_gather=1), an active lane i receives the partner's data when the partner's mask bit is set, and receives 0 when it is clear.
- R3: In scatter mode (in_gather=0), an active lane i writes its own data into the partner's slot when the partner's mask bit is set, and writes 0 into that slot when it is clear.
- R4: In scatter mode, when several active lanes name the same slot, the highest-numbered of those lanes decides the slot's value.
- R5: A result slot written by no active lane equals the matching word of in_prior. This covers inactive lanes in gather mode, untargeted slots in scatter mode, and an all-zero mask in either mode.
- R6: A nonzero in_offset1 sets out_err together with that operation's done pulse. The result ignores in_offset1. out_err is never high without out_done.
- R7: If in_valid and in_ready are both high in cycle c, out_done is high for exactly one cycle, in cycle c+24. Operations issued in consecutive cycles each produce their own pulse, in order.
- R8: Mode, mask, offsets and operand vectors are captured in the issue cycle. Input changes after that cycle do not alter the operation's result.
- R9: While rst_n is low, in_ready, out_done and out_err are 0. After reset is released, in_ready rises and stays high.
- R10: The address-plus-offset sum wraps modulo 2^32 before the index bits are taken. For example, 0xFFFFFFFC + 8 selects lane 1, and address bits above bit 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit accepts an operation this cycle |
| in_gather | input | 1 | 1 = gather (pull from partner), 0 = scatter (push to partner) |
| in_exec | input | 64 | Per-lane execution mask |
| in_offset0 | input | 8 | Immediate added to every lane address |
| in_offset1 | input | 8 | Second immediate; must be zero |
| in_addr | input | 2048 | Lane byte addresses, lane i at bits [32i+31:32i] |
| in_data | input | 2048 | Lane data words, same packing |
| in_prior | input | 2048 | Prior destination contents, same packing |
| out_done | output | 1 | One-cycle pulse per completed operation |
| out_err | output | 1 | Offset1 was nonzero for the completing operation |
| out_result | output | 2048 | Permuted result, valid with out_done |

## Verification
The bench aims at the wrap of the address sum: a design that took the index from the wrong bits, or that did not wrap the sum at 32 bits, would send lanes to the wrong partner. In scatter mode it drives every lane at one slot, with and without the top lane active. A wrong conflict priority would leave a lower lane's word in that slot. Masked-off partners and an empty mask are tested so that a design which skips the zeroing, or which drops the prior value, shows a wrong word in a specific lane. The bench also changes every input in the cycle after issue, sends back-to-back bursts, and offers a nonzero second offset. A design that read late inputs, lost or merged done pulses, or let the second offset change the result would be caught.

// File: rtl/perm_pkg.sv
package perm_pkg;

  localparam int unsigned NLANES   = 64;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned OFF_W    = 8;
  localparam int unsigned PIPE_LAT = 24;

  typedef enum logic {
    MODE_SCATTER = 1'b0,
    MODE_GATHER  = 1'b1
  } perm_mode_e;

endpackage

// File: rtl/perm_issue_stage.sv
module perm_issue_stage #(
  parameter int LANES = 64,
  parameter int WORD  = 32,
  parameter int OFFW  = 8,
  localparam int VECW = LANES * WORD
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fire,
  input  perm_pkg::perm_mode_e mode,
  input  logic [LANES-1:0]     exec,
  input  logic [OFFW-1:0]      off0,
  input  logic [OFFW-1:0]      off1,
  input  logic [VECW-1:0]      addr,
  input  logic [VECW-1:0]      data,
  input  logic [VECW-1:0]      prior,
  output logic                 cap_valid,
  output perm_pkg::perm_mode_e cap_mode,
  output logic [LANES-1:0]     cap_exec,
  output logic [OFFW-1:0]      cap_off0,
  output logic                 cap_err,
  output logic [VECW-1:0]      cap_addr,
  output logic [VECW-1:0]      cap_data,
  output logic [VECW-1:0]      cap_prior
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cap_valid <= 1'b0;
    else        cap_valid <= fire;
  end

  // Operands load only on an accepted issue; they hold otherwise.
  always_ff @(posedge clk) begin
    if (fire) begin
      cap_mode  <= mode;
      cap_exec  <= exec;
      cap_off0  <= off0;
      cap_err   <= |off1;
      cap_addr  <= addr;
      cap_data  <= data;
      cap_prior <= prior;
    end
  end

endmodule

// File: rtl/perm_crossbar.sv
module perm_crossbar #(
  parameter int LANES = 64,
  parameter int WORD  = 32,
  parameter int OFFW  = 8,
  localparam int LIDX = $clog2(LANES),
  localparam int VECW = LANES * WORD
) (
  input  perm_pkg::perm_mode_e mode,
  input  logic [LANES-1:0]     exec,
  input  logic [OFFW-1:0]      off,
  input  logic [VECW-1:0]      addr,
  input  logic [VECW-1:0]      data,
  input  logic [VECW-1:0]      prior,
  output logic [VECW-1:0]      result
);

  // Byte address plus immediate, wrapped at WORD bits, converted to a
  // word index; the upper bits drop out, giving the modulo-LANES lane.
  function automatic logic [LIDX-1:0] lane_of(input logic [WORD-1:0] a,
                                              input logic [OFFW-1:0] o);
    logic [WORD-1:0] sum;
    sum = a + WORD'(o);
    return sum[LIDX+1:2];
  endfunction

  logic [LIDX-1:0] partner [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_idx
    assign partner[g] = lane_of(addr[g*WORD +: WORD], off);
  end

  always_comb begin
    result = prior;
    for (int d = 0; d < LANES; d++) begin
      logic [LIDX-1:0] win;
      logic            hit;
      win = '0;
      hit = 1'b0;
      if (mode == perm_pkg::MODE_GATHER) begin
        if (exec[d]) begin
          result[d*WORD +: WORD] = exec[partner[d]] ?
                                   data[partner[d]*WORD +: WORD] : '0;
        end
      end else begin
        // Ascending scan: the last match, the highest lane, wins.
        for (int l = 0; l < LANES; l++) begin
          if (exec[l] && (partner[l] == LIDX'(d))) begin
            win = LIDX'(l);
            hit = 1'b1;
          end
        end
        if (hit) begin
          result[d*WORD +: WORD] = exec[d] ? data[win*WORD +: WORD] : '0;
        end
      end
    end
  end

endmodule

// File: rtl/perm_delay.sv
module perm_delay #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] in_payload,
  output logic             out_valid,
  output logic [WIDTH-1:0] out_payload
);

  logic [DEPTH-1:0] vld_q;
  logic [WIDTH-1:0] pay_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else begin
      vld_q[0] <= in_valid;
      for (int i = 1; i < DEPTH; i++) vld_q[i] <= vld_q[i-1];
    end
  end

  // Payload stages load only behind a valid bit, so idle slots stay quiet.
  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    if (s == 0) begin : g_head
      always_ff @(posedge clk) if (in_valid) pay_q[0] <= in_payload;
    end else begin : g_body
      always_ff @(posedge clk) if (vld_q[s-1]) pay_q[s] <= pay_q[s-1];
    end
  end

  assign out_valid   = vld_q[DEPTH-1];
  assign out_payload = pay_q[DEPTH-1];

endmodule

// File: rtl/lane_permute_unit.sv
module lane_permute_unit #(
  parameter int LANES   = perm_pkg::NLANES,
  parameter int WORD    = perm_pkg::DATA_W,
  parameter int OFFW    = perm_pkg::OFF_W,
  parameter int LATENCY = perm_pkg::PIPE_LAT,
  localparam int VECW   = LANES * WORD,
  localparam int DEPTH  = LATENCY - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_gather,
  input  logic [LANES-1:0]  in_exec,
  input  logic [OFFW-1:0]   in_offset0,
  input  logic [OFFW-1:0]   in_offset1,
  input  logic [VECW-1:0]   in_addr,
  input  logic [VECW-1:0]   in_data,
  input  logic [VECW-1:0]   in_prior,
  output logic              out_done,
  output logic              out_err,
  output logic [VECW-1:0]   out_result
);

  logic                 rdy_q;
  logic                 iss_fire;
  logic                 cap_valid;
  perm_pkg::perm_mode_e cap_mode;
  logic                 cap_gather;
  logic [LANES-1:0]     cap_exec;
  logic [OFFW-1:0]      cap_off0;
  logic                 cap_err;
  logic [VECW-1:0]      cap_addr;
  logic [VECW-1:0]      cap_data;
  logic [VECW-1:0]      cap_prior;
  logic [VECW-1:0]      xb_result;
  logic                 dl_valid;
  logic [VECW:0]        dl_payload;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= 1'b1;
  end

  assign in_ready   = rdy_q;
  assign iss_fire   = in_valid && rdy_q;
  assign cap_gather = (cap_mode == perm_pkg::MODE_GATHER);

  perm_issue_stage #(.LANES(LANES), .WORD(WORD), .OFFW(OFFW)) u_issue (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (iss_fire),
    .mode      (perm_pkg::perm_mode_e'(in_gather)),
    .exec      (in_exec),
    .off0      (in_offset0),
    .off1      (in_offset1),
    .addr      (in_addr),
    .data      (in_data),
    .prior     (in_prior),
    .cap_valid (cap_valid),
    .cap_mode  (cap_mode),
    .cap_exec  (cap_exec),
    .cap_off0  (cap_off0),
    .cap_err   (cap_err),
    .cap_addr  (cap_addr),
    .cap_data  (cap_data),
    .cap_prior (cap_prior)
  );

  perm_crossbar #(.LANES(LANES), .WORD(WORD), .OFFW(OFFW)) u_xbar (
    .mode   (cap_mode),
    .exec   (cap_exec),
    .off    (cap_off0),
    .addr   (cap_addr),
    .data   (cap_data),
    .prior  (cap_prior),
    .result (xb_result)
  );

  perm_delay #(.WIDTH(VECW + 1), .DEPTH(DEPTH)) u_delay (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (cap_valid),
    .in_payload  ({cap_err, xb_result}),
    .out_valid   (dl_valid),
    .out_payload (dl_payload)
  );

  assign out_done   = dl_valid;
  assign out_err    = dl_valid && dl_payload[VECW];
  assign out_result = dl_payload[VECW-1:0];

endmodule

// File: rtl/perm_checker.sv
module perm_checker #(
  parameter int LANES = 64,
  parameter int WORD  = 32,
  parameter int OFFW  = 8,
  parameter int LAT   = 24,
  localparam int VECW = LANES * WORD
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [OFFW-1:0]   in_offset1,
  input logic              out_done,
  input logic              out_err,
  input logic              iss_fire,
  input logic              cap_valid,
  input logic              cap_gather,
  input logic [LANES-1:0]  cap_exec,
  input logic [VECW-1:0]   cap_prior,
  input logic [VECW-1:0]   xb_result
);

  logic [LAT-1:0] fire_sh;
  logic [LAT-1:0] err_sh;
  logic           rst_seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fire_sh <= '0;
      err_sh  <= '0;
    end else begin
      fire_sh <= {fire_sh[LAT-2:0], in_valid && in_ready};
      err_sh  <= {err_sh[LAT-2:0], in_valid && in_ready && (in_offset1 != '0)};
    end
  end

  always @(posedge clk) begin
    if (!rst_n && rst_seen_q) begin
      AST_QUIET_IN_RESET: assert (!in_ready && !out_done && !out_err); // R9
    end
    rst_seen_q <= !rst_n;
  end

  AST_DONE_ON_TIME: assert property (@(posedge clk) disable iff (!rst_n)
    out_done == fire_sh[LAT-1]); // R7

  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    out_err |-> out_done); // R6

  AST_ERR_FOLLOWS_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |-> (out_err == err_sh[LAT-1])); // R6

  AST_ISSUE_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
    iss_fire |=> cap_valid); // R8

  AST_NO_PHANTOM_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    !iss_fire |=> !cap_valid); // R8

  AST_IDLE_LANE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_valid && cap_gather && !cap_exec[0]) |->
      (xb_result[WORD-1:0] == cap_prior[WORD-1:0])); // R5

  AST_EMPTY_MASK_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_valid && (cap_exec == '0)) |-> (xb_result == cap_prior)); // R5

endmodule

bind lane_permute_unit perm_checker #(
  .LANES(LANES), .WORD(WORD), .OFFW(OFFW), .LAT(LATENCY)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_offset1 (in_offset1),
  .out_done   (out_done),
  .out_err    (out_err),
  .iss_fire   (iss_fire),
  .cap_valid  (cap_valid),
  .cap_gather (cap_gather),
  .cap_exec   (cap_exec),
  .cap_prior  (cap_prior),
  .xb_result  (xb_result)
);

// File: tb/sim_lane_permute_unit.sv
`timescale 1ns/1ps
module sim_lane_permute_unit;

  localparam int L   = 64;
  localparam int W   = 32;
  localparam int LAT = 24;
  localparam int VW  = L * W;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_gather = 1'b0;
  logic [L-1:0]  in_exec = '0;
  logic [7:0]    in_offset0 = '0;
  logic [7:0]    in_offset1 = '0;
  logic [VW-1:0] in_addr = '0;
  logic [VW-1:0] in_data = '0;
  logic [VW-1:0] in_prior = '0;
  logic          in_ready;
  logic          out_done;
  logic          out_err;
  logic [VW-1:0] out_result;

  always #2.5 clk = ~clk;

  lane_permute_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_gather(in_gather), .in_exec(in_exec), .in_offset0(in_offset0),
    .in_offset1(in_offset1), .in_addr(in_addr), .in_data(in_data),
    .in_prior(in_prior), .out_done(out_done), .out_err(out_err),
    .out_result(out_result)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  string tag = "R9";

  logic [31:0] a_addr [L];
  logic [31:0] a_data [L];
  logic [31:0] a_prior [L];

  logic [VW-1:0] q_res [$];
  logic          q_err [$];
  int            q_due [$];
  string         q_tag [$];

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Reference: initiators walk in ascending order over a lane array.
  function automatic logic [VW-1:0] ref_perm(input logic g, input logic [L-1:0] ex,
      input logic [7:0] o0, input logic [VW-1:0] ad, input logic [VW-1:0] dt,
      input logic [VW-1:0] pr);
    logic [31:0] res [L];
    logic [VW-1:0] flat;
    int p;
    for (int l = 0; l < L; l++) res[l] = pr[l*W +: W];
    for (int l = 0; l < L; l++) begin
      if (ex[l]) begin
        p = int'(((ad[l*W +: W] + {24'h0, o0}) >> 2) & 32'h3F);
        if (g) res[l] = ex[p] ? dt[p*W +: W] : 32'h0;
        else   res[p] = ex[p] ? dt[l*W +: W] : 32'h0;
      end
    end
    for (int l = 0; l < L; l++) flat[l*W +: W] = res[l];
    return flat;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      logic due_now;
      cyc++;
      due_now = (q_due.size() > 0) && (q_due[0] == cyc);
      chk("R7", "done pulse", 64'(out_done), 64'(due_now));
      if (due_now) begin
        logic [VW-1:0] er;
        logic ee;
        string tg;
        int bad_lane;
        er = q_res.pop_front();
        ee = q_err.pop_front();
        tg = q_tag.pop_front();
        void'(q_due.pop_front());
        bad_lane = -1;
        for (int l = L - 1; l >= 0; l--)
          if (out_result[l*W +: W] !== er[l*W +: W]) bad_lane = l;
        if (bad_lane < 0) chk(tg, "result", 64'd0, 64'd0);
        else chk(tg, $sformatf("result lane %0d", bad_lane),
                 64'(out_result[bad_lane*W +: W]), 64'(er[bad_lane*W +: W]));
        chk("R6", "error flag", 64'(out_err), 64'(ee));
      end else if (out_err) begin
        chk("R6", "error without done", 64'(out_err), 64'd0);
      end
      if (in_valid && in_ready) begin
        q_res.push_back(ref_perm(in_gather, in_exec, in_offset0, in_addr, in_data, in_prior));
        q_err.push_back(in_offset1 != 8'h0);
        q_due.push_back(cyc + LAT);
        q_tag.push_back(tag);
      end
    end
  end

  task automatic put_op(input string t, input logic g, input logic [L-1:0] ex,
                        input logic [7:0] o0, input logic [7:0] o1);
    @(posedge clk);
    #1;
    for (int l = 0; l < L; l++) begin
      in_addr[l*W +: W]  = a_addr[l];
      in_data[l*W +: W]  = a_data[l];
      in_prior[l*W +: W] = a_prior[l];
    end
    tag = t;
    in_gather = g;
    in_exec = ex;
    in_offset0 = o0;
    in_offset1 = o1;
    in_valid = 1'b1;
  endtask

  task automatic go_idle();
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic fresh_values(input int seed);
    for (int l = 0; l < L; l++) begin
      a_data[l]  = 32'hD000_0000 + (seed << 12) + l;
      a_prior[l] = 32'h7000_0000 + (seed << 12) + l;
    end
  endtask

  initial begin
    fork
      begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    join_none

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9", "ready in reset", 64'(in_ready), 64'd0);
    chk("R9", "done in reset", 64'(out_done), 64'd0);
    chk("R9", "err in reset", 64'(out_err), 64'd0);
    @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R9", "ready after reset", 64'(in_ready), 64'd1);

    // R1/R2: gather rotate by one lane
    fresh_values(1);
    for (int l = 0; l < L; l++) a_addr[l] = 32'(4 * ((l + 1) % L));
    put_op("R1", 1'b1, '1, 8'd0, 8'd0);
    go_idle();

    // R1: offset adds two words
    fresh_values(2);
    for (int l = 0; l < L; l++) a_addr[l] = 32'(4 * l);
    put_op("R1", 1'b1, '1, 8'd8, 8'd0);
    go_idle();

    // R10: 32-bit wrap and high address bits ignored
    fresh_values(3);
    for (int l = 0; l < L; l++)
      a_addr[l] = (l % 2 == 0) ? 32'hFFFF_FFFC : 32'(256 * 7 + 4 * l);
    put_op("R10", 1'b1, '1, 8'd8, 8'd0);
    go_idle();

    // R2: gather with half the lanes masked off
    fresh_values(4);
    for (int l = 0; l < L; l++) a_addr[l] = 32'(4 * (L - 1 - l));
    put_op("R2", 1'b1, 64'h5555_5555_5555_5555, 8'd0, 8'd0);
    go_idle();

    // R3: scatter reverse, all lanes active
    fresh_values(5);
    for (int l = 0; l < L; l++) a_addr[l] = 32'(4 * (L - 1 - l));
    put_op("R3", 1'b0, '1, 8'd0, 8'd0);
    go_idle();

    // R3: scatter rotate with partial mask (inactive targets get 0)
    fresh_values(6);
    for (int l = 0; l < L; l++) a_addr[l] = 32'(4 * ((l + 3) % L));
    put_op("R3", 1'b0, 64'hF0F0_0FF0_3C3C_A5A5, 8'd0, 8'd0);
    go_idle();

    // R4: every lane targets slot 5; highest active lane wins
    fresh_values(7);
    for (int l = 0; l < L; l++) a_addr[l] = 32'd20;
    put_op("R4", 1'b0, '1, 8'd0, 8'd0);
    put_op("R4", 1'b0, 64'h7FFF_FFFF_FFFF_FFFF, 8'd0, 8'd0);
    go_idle();

    // R5: empty mask in both modes, and scatter leaving slots untouched
    fresh_values(8);
    for (int l = 0; l < L; l++) a_addr[l] = 32'(4 * l);
    put_op("R5", 1'b1, '0, 8'd0, 8'd0);
    put_op("R5", 1'b0, '0, 8'd0, 8'd0);
    for (int l = 0; l < L; l++) a_addr[l] = 32'd0;
    put_op("R5", 1'b0, 64'h0000_0000_0000_0F01, 8'd0, 8'd0);
    go_idle();

    // R6: nonzero second offset flags and is ignored
    fresh_values(9);
    for (int l = 0; l < L; l++) a_addr[l] = 32'(4 * l);
    put_op("R6", 1'b1, '1, 8'd4, 8'd3);
    go_idle();

    // R8: every input changes right after the issue cycle
    fresh_values(10);
    for (int l = 0; l < L; l++) a_addr[l] = 32'(4 * ((l * 5) % L));
    put_op("R8", 1'b1, 64'hFFFF_0000_FFFF_00FF, 8'd12, 8'd0);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    in_gather = 1'b0;
    in_exec = ~in_exec;
    in_offset0 = 8'hA4;
    in_addr = ~in_addr;
    in_data = ~in_data;
    in_prior = ~in_prior;
    repeat (4) @(posedge clk);

    // R7: back-to-back burst of random operations
    for (int k = 0; k < 8; k++) begin
      for (int l = 0; l < L; l++) begin
        a_addr[l]  = $urandom;
        a_data[l]  = $urandom;
        a_prior[l] = $urandom;
      end
      put_op("R7", 1'($urandom), {32'($urandom), 32'($urandom)}, 8'($urandom), 8'd0);
    end
    go_idle();

    for (int w = 0; w < 200 && q_due.size() > 0; w++) @(posedge clk);
    repeat (3) @(negedge clk);
    chk("R7", "all operations completed", 64'(q_due.size()), 64'd0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule